// File: doc/BRIEF.md
# Bidirectional Cascadable Gate-Line Scanner

This block selects display rows one at a time. A start pulse is sampled on the rising edge of the shift clock and moves through a chain of `STAGES` registers, one stage per rising edge. Each stage drives one gate-select output. Several chips can be chained in a row: the last stage of the chain is passed on as a cascade pulse to the next chip, and that pulse is registered on the falling clock edge.

A direction input selects which end of the chain takes the start pulse and which end sends the cascade pulse. Each of the two shared start-pulse pins is modelled as a separate input, output and drive enable. The pin that is the cascade output for the current direction is driven, and the other pin is left undriven. Three mask inputs each force one interleaved third of the gate outputs inactive. This lets a timing controller make gaps between neighbouring rows.

Top module: `gate_scan_top`

## Requirements
- R1: While `rst_ni` is low, all stages and the cascade register are cleared asynchronously, so every `gate_o` bit and both `pin_a_o` and `pin_b_o` read 0.
- R2: When `dir_up_i` is 1, each rising edge of `clk_i` loads `pin_a_i` into stage 1, which drives `gate_o[0]`.
- R3: When `dir_up_i` is 1, each rising edge moves the content of stage k into stage k+1. Any number of 1s may be in the chain at once.
- R4: When `dir_up_i` is 0, each rising edge loads `pin_b_i` into the last stage (`gate_o[STAGES-1]`) and moves the content of stage k+1 into stage k.
- R5: On each falling edge, the cascade register takes the last stage for the current direction: stage `STAGES` when shifting up, stage 1 when shifting down. A 1 that enters at rising edge 1 therefore shows on the cascade pin at the falling edge of rising edge `STAGES`, and not before.
- R6: When `dir_up_i` is 1, `pin_b_oe` is 1, `pin_a_oe` is 0 and `pin_b_o` carries the cascade register. When `dir_up_i` is 0 the roles are swapped. The undriven output always reads 0.
- R7: Output `gate_o[k]` (0-based) equals stage k+1 AND NOT `mask_i[k mod 3]`. So `mask_i[0]` covers G1, G4, G7 …, `mask_i[1]` covers G2, G5 …, and `mask_i[2]` covers G3, G6 ….
- R8: A change of `dir_up_i` takes effect at the next rising edge, and the stored stage contents are kept unchanged.
- R9: The start-pulse input on the non-entry pin (`pin_b_i` when shifting up, `pin_a_i` when shifting down) has no effect on any stage.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Shift clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| dir_up_i | input | 1 | 1: shift G1 toward G256; 0: shift G256 toward G1 |
| pin_a_i | input | 1 | First start-pulse pin, input side |
| pin_a_o | output | 1 | First start-pulse pin, output side (cascade when shifting down) |
| pin_a_oe | output | 1 | Drive enable of the first pin |
| pin_b_i | input | 1 | Second start-pulse pin, input side |
| pin_b_o | output | 1 | Second start-pulse pin, output side (cascade when shifting up) |
| pin_b_oe | output | 1 | Drive enable of the second pin |
| mask_i | input | 3 | Group masks; bit g forces off outputs whose index mod 3 is g |
| gate_o | output | 256 | Gate-select outputs, bit 0 is G1 |

## Verification
On every cycle the assertions check that the chain moves one stage per rising edge in the selected direction, with the correct entry pin. They also check that the cascade register follows the correct end of the chain on the falling edge, that exactly one pin drive enable is active, and that no gate is active unless its stage holds a 1. The bench scenarios are needed for the rest. These are the 256-edge latency of the cascade pulse, the full sweep of all eight mask combinations against group population counts, and stored contents surviving a change of direction.

// File: rtl/gs_pkg.sv
package gs_pkg;
   // Group (mask select) of a 0-based gate index.
   function automatic int unsigned group_of(input int unsigned idx, input int unsigned groups);
      return idx % groups;
   endfunction
endpackage

// File: rtl/gs_shift_chain.sv
module gs_shift_chain #(
   parameter int unsigned STAGES = 256
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              dir_up_i,
   input  logic              head_up_i,
   input  logic              head_dn_i,
   output logic [STAGES-1:0] stage_o
);
   localparam int unsigned LAST = STAGES - 1;

   if (STAGES < 2) begin : g_bad_stages
      $error("gs_shift_chain: STAGES must be at least 2");
   end

   logic [STAGES-1:0] stage_q;

   for (genvar i = 0; i < STAGES; i++) begin : g_stage
      logic from_lo;
      logic from_hi;
      if (i == 0) begin : g_lo_edge
         assign from_lo = head_up_i;
      end else begin : g_lo_mid
         assign from_lo = stage_q[i-1];
      end
      if (i == LAST) begin : g_hi_edge
         assign from_hi = head_dn_i;
      end else begin : g_hi_mid
         assign from_hi = stage_q[i+1];
      end
      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni) stage_q[i] <= 1'b0;
         else         stage_q[i] <= dir_up_i ? from_lo : from_hi;
      end
   end

   assign stage_o = stage_q;

   AST_UP_ENTRY: assert property (@(posedge clk_i) disable iff (!rst_ni)
      dir_up_i |=> stage_q[0] == $past(head_up_i)); // R2
   AST_UP_MOVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      dir_up_i |=> stage_q[LAST:1] == $past(stage_q[LAST-1:0])); // R3
   AST_DN_MOVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !dir_up_i |=> {$past(head_dn_i), $past(stage_q[LAST:1])} == stage_q); // R4
endmodule

// File: rtl/gs_cascade_port.sv
module gs_cascade_port (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic dir_up_i,
   input  logic tail_up_i,
   input  logic tail_dn_i,
   output logic pin_a_o,
   output logic pin_a_oe,
   output logic pin_b_o,
   output logic pin_b_oe
);
   logic casc_q;

   always_ff @(negedge clk_i or negedge rst_ni) begin
      if (!rst_ni) casc_q <= 1'b0;
      else         casc_q <= dir_up_i ? tail_up_i : tail_dn_i;
   end

   assign pin_b_oe = dir_up_i;
   assign pin_a_oe = ~dir_up_i;
   assign pin_b_o  = dir_up_i & casc_q;
   assign pin_a_o  = ~dir_up_i & casc_q;

   AST_CASC_UP: assert property (@(negedge clk_i) disable iff (!rst_ni)
      dir_up_i |=> casc_q == $past(tail_up_i)); // R5
   AST_CASC_DN: assert property (@(negedge clk_i) disable iff (!rst_ni)
      !dir_up_i |=> casc_q == $past(tail_dn_i)); // R5
   AST_ONE_DRIVER: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $onehot({pin_a_oe, pin_b_oe})); // R6
endmodule

// File: rtl/gs_group_mask.sv
module gs_group_mask #(
   parameter int unsigned STAGES = 256,
   parameter int unsigned GROUPS = 3
) (
   input  logic [STAGES-1:0] stage_i,
   input  logic [GROUPS-1:0] mask_i,
   output logic [STAGES-1:0] gate_o
);
   import gs_pkg::*;

   if (GROUPS < 1 || GROUPS > STAGES) begin : g_bad_groups
      $error("gs_group_mask: GROUPS must be in 1..STAGES");
   end

   for (genvar k = 0; k < STAGES; k++) begin : g_gate
      localparam int unsigned GSEL = group_of(k, GROUPS);
      assign gate_o[k] = stage_i[k] & ~mask_i[GSEL];
   end
endmodule

// File: rtl/gate_scan_top.sv
module gate_scan_top #(
   parameter int unsigned STAGES = 256,
   parameter int unsigned GROUPS = 3
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              dir_up_i,
   input  logic              pin_a_i,
   output logic              pin_a_o,
   output logic              pin_a_oe,
   input  logic              pin_b_i,
   output logic              pin_b_o,
   output logic              pin_b_oe,
   input  logic [GROUPS-1:0] mask_i,
   output logic [STAGES-1:0] gate_o
);
   logic [STAGES-1:0] stage_w;

   gs_shift_chain #(.STAGES(STAGES)) chain_i (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .dir_up_i (dir_up_i),
      .head_up_i(pin_a_i),
      .head_dn_i(pin_b_i),
      .stage_o  (stage_w)
   );

   gs_cascade_port casc_i (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .dir_up_i (dir_up_i),
      .tail_up_i(stage_w[STAGES-1]),
      .tail_dn_i(stage_w[0]),
      .pin_a_o  (pin_a_o),
      .pin_a_oe (pin_a_oe),
      .pin_b_o  (pin_b_o),
      .pin_b_oe (pin_b_oe)
   );

   gs_group_mask #(.STAGES(STAGES), .GROUPS(GROUPS)) mask_u (
      .stage_i(stage_w),
      .mask_i (mask_i),
      .gate_o (gate_o)
   );

   AST_GATE_NEEDS_STAGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (gate_o & ~stage_w) == '0); // R7
   AST_ALL_MASKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (&mask_i) |-> gate_o == '0); // R7
endmodule

// File: tb/gate_scan_top_tb.sv
module gate_scan_top_tb_top;
   localparam int CLK_PERIOD = 10;
   localparam int N = 256;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic dir_up = 1'b1;
   logic a_in = 1'b0, b_in = 1'b0;
   logic a_out, a_oe, b_out, b_oe;
   logic [2:0] mask = 3'b000;
   logic [N-1:0] gate;

   int checks = 0;
   int errors = 0;
   logic [N-1:0] ref_q = '0;
   logic casc_m = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   gate_scan_top dut_i (
      .clk_i(clk), .rst_ni(rst_n), .dir_up_i(dir_up),
      .pin_a_i(a_in), .pin_a_o(a_out), .pin_a_oe(a_oe),
      .pin_b_i(b_in), .pin_b_o(b_out), .pin_b_oe(b_oe),
      .mask_i(mask), .gate_o(gate)
   );

   function automatic logic [N-1:0] expect_gates();
      logic [N-1:0] e;
      for (int k = 0; k < N; k++) e[k] = ref_q[k] & ~mask[k % 3];
      return e;
   endfunction

   task automatic check_vec(string req, logic [N-1:0] act, logic [N-1:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic check_bit(string req, logic act, logic exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%b expected=%b", req, act, exp);
      end
   endtask

   // Inputs are already set; one rising and one falling edge follow.
   task automatic step(string req);
      @(posedge clk);
      ref_q = dir_up ? {ref_q[N-2:0], a_in} : {b_in, ref_q[N-1:1]};
      #2;
      check_vec(req, gate, expect_gates());
      @(negedge clk);
      casc_m = dir_up ? ref_q[N-1] : ref_q[0];
      #1;
      check_bit("R6 b_oe", b_oe, dir_up);
      check_bit("R6 a_oe", a_oe, ~dir_up);
      check_bit("R5/R6 b_o", b_out, dir_up & casc_m);
      check_bit("R5/R6 a_o", a_out, ~dir_up & casc_m);
   endtask

   initial begin
      #(CLK_PERIOD * 200000);
      errors++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      // R1: reset state
      #22;
      check_vec("R1 gates in reset", gate, '0);
      check_bit("R1 pin_b_o in reset", b_out, 1'b0);
      check_bit("R1 pin_a_o in reset", a_out, 1'b0);
      check_bit("R6 b_oe in reset", b_oe, 1'b1);
      @(negedge clk); #1 rst_n = 1'b1;

      // R2/R3/R5: single pulse up, cascade at falling edge of 256th clock
      a_in = 1'b1;
      step("R2 entry");
      a_in = 1'b0;
      for (int s = 2; s <= N + 2; s++) begin
         step("R3 shift up");
         if (s == N - 1) check_bit("R5 cascade not early", b_out, 1'b0);
         if (s == N)     check_bit("R5 cascade at edge 256", b_out, 1'b1);
         if (s == N + 1) check_bit("R5 cascade drops", b_out, 1'b0);
      end

      // R3/R9: several pulses in flight, non-entry pin toggling
      for (int s = 0; s < 60; s++) begin
         a_in = (s % 5 == 0) || (s % 7 == 3);
         b_in = s[0];
         step("R9 b ignored while up");
      end
      a_in = 1'b0; b_in = 1'b0;

      // R8: direction reversal keeps contents
      dir_up = 1'b0;
      #1 check_vec("R8 contents kept on reversal", gate, expect_gates());
      for (int s = 0; s < 30; s++) begin
         a_in = s[1];
         step("R8/R9 down after reversal");
      end
      dir_up = 1'b1;
      for (int s = 0; s < 10; s++) step("R8 back up");

      // R4/R5: single pulse down through the whole chain
      dir_up = 1'b0; a_in = 1'b0;
      for (int s = 0; s < N; s++) step("R4 flush");
      b_in = 1'b1;
      step("R4 entry at last stage");
      b_in = 1'b0;
      for (int s = 2; s <= N + 1; s++) begin
         step("R4 shift down");
         if (s == N - 1) check_bit("R5 down cascade not early", a_out, 1'b0);
         if (s == N)     check_bit("R5 down cascade at edge 256", a_out, 1'b1);
      end

      // R7: fill with ones, sweep all mask codes, compare population
      b_in = 1'b1;
      for (int s = 0; s < N; s++) step("R7 fill");
      for (int m = 0; m < 8; m++) begin
         mask = m[2:0];
         step("R7 mask sweep");
         checks++;
         if ($countones(gate) != ((m & 1) ? 0 : 86) + ((m & 2) ? 0 : 85) + ((m & 4) ? 0 : 85)) begin
            errors++;
            $display("FAIL R7 population: actual=%0d expected=%0d", $countones(gate),
                     ((m & 1) ? 0 : 86) + ((m & 2) ? 0 : 85) + ((m & 4) ? 0 : 85));
         end
      end
      mask = 3'b000;

      // R1: asynchronous reset mid-run
      #2 rst_n = 1'b0;
      #1 check_vec("R1 async clear", gate, '0);
      ref_q = '0;
      @(negedge clk); #1 rst_n = 1'b1;

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule